// File: doc/BRIEF.md
# Two-Level Zero-Overhead Loop Controller

This block sits beside an instruction fetch stage and removes the branch at the bottom of counted loops. A loop setup instruction, presented together with its own program counter and the value of its first source register, loads a start address, an end address and an iteration count into one of two loop register sets. From then on, each valid fetch address is compared with the end address of every armed level. When it matches and more iterations remain, the block asks fetch to continue at the loop start instead of the next sequential address, and it counts that iteration down.

Level 0 is the inner loop and wins when both levels would redirect on the same fetch. A level whose count is spent does not block the other, so an inner and an outer loop may share the same last instruction. The count comes either from the source register or from an immediate field, depending on the setup form. The register contents are exported so that neighbouring logic can observe them.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset every loop register (start, end, count) of both levels is zero and `redirect_o` is low.
- R2: A setup instruction is recognised when `setup_valid_i` is high, bits [6:0] equal 7'b1111011 and bits [11:8] are zero. With bits [14:12] = 3'b100 (register form) the selected level gets start = PC + 4, end = PC + (bits[31:20] zero-extended, shifted left by one) and count = `rs1_val_i`.
- R3: With bits [14:12] = 3'b101 (immediate form) the selected level gets start = PC + 4, end = PC + (bits[19:15] zero-extended, shifted left by one) and count = bits[31:20] zero-extended.
- R4: A setup with `setup_valid_i` low, another opcode, nonzero bits [11:8] or any other value of bits [14:12] changes no loop register.
- R5: Bit 7 of the setup instruction selects the level written (0 or 1); the other level keeps its contents.
- R6: When `fetch_valid_i` is high, `fetch_pc_i` equals a level's end and its count is greater than 1, `redirect_o` rises in the same cycle with `redirect_pc_o` equal to that level's start, and the count is one lower from the next cycle.
- R7: At a matching end with count 1 the block does not redirect for that level and the count becomes 0; a level with count 0 never redirects and its count stays 0.
- R8: When both levels would redirect on one fetch, the target is level 0's start and level 1's count is not changed.
- R9: A level 0 match with count 1 does not stop level 1 from redirecting on the same fetch.
- R10: Register writes from a setup take effect for fetches after the setup cycle; a fetch in the setup cycle uses the old values, and the setup overrides any count step on that level in that cycle.
- R11: With `fetch_valid_i` low, `redirect_o` stays low and no count changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| setup_valid_i | input | 1 | A decoded instruction is presented for setup |
| setup_instr_i | input | 32 | Instruction word of the setup candidate |
| setup_pc_i | input | AW (32) | Address of the setup instruction |
| rs1_val_i | input | CW (32) | First source register value (count of the register form) |
| fetch_valid_i | input | 1 | Fetch address strobe |
| fetch_pc_i | input | AW (32) | Address being fetched |
| redirect_o | output | 1 | Fetch must continue at `redirect_pc_o` |
| redirect_pc_o | output | AW (32) | Loop start to fetch next |
| loop_start_o | output | 2*AW (64) | Start addresses, level 0 in the low half |
| loop_end_o | output | 2*AW (64) | End addresses, level 0 in the low half |
| loop_count_o | output | 2*CW (64) | Remaining counts, level 0 in the low half |

## Verification
The assertions assume that a setup and a fetch are separate, independent strobes and that a fetch address is only meaningful while its strobe is high; they do not assume any order of setup and fetch, so the stimulus deliberately places a setup and a matching fetch in one cycle. The stimulus keeps every end offset within its field width and every count within the count width, walks a nested loop by presenting only the addresses that matter (loop entries, loop ends, fall-through points), and re-issues the inner setup on each outer iteration as real code would.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;
   localparam int unsigned INSTR_W    = 32;
   localparam logic [6:0]  SETUP_OPC  = 7'b1111011;
   localparam logic [2:0]  F3_REGCNT  = 3'b100;
   localparam logic [2:0]  F3_IMMCNT  = 3'b101;

   typedef enum logic [1:0] {
      FORM_NONE   = 2'd0,
      FORM_REGCNT = 2'd1,
      FORM_IMMCNT = 2'd2
   } setup_form_e;

   function automatic setup_form_e classify(input logic [INSTR_W-1:0] instr);
      if (instr[6:0] != SETUP_OPC || instr[11:8] != 4'd0) return FORM_NONE;
      if (instr[14:12] == F3_REGCNT) return FORM_REGCNT;
      if (instr[14:12] == F3_IMMCNT) return FORM_IMMCNT;
      return FORM_NONE;
   endfunction
endpackage

// File: rtl/hwloop_decode.sv
module hwloop_decode
   import hwloop_pkg::*;
#(
   parameter int unsigned AW      = 32,
   parameter int unsigned CW      = 32,
   parameter int unsigned NLEVELS = 2
) (
   input  logic                 valid_i,
   input  logic [INSTR_W-1:0]   instr_i,
   input  logic [AW-1:0]        pc_i,
   input  logic [CW-1:0]        rs1_i,
   output logic [NLEVELS-1:0]   wr_en_o,
   output logic [AW-1:0]        wr_start_o,
   output logic [AW-1:0]        wr_end_o,
   output logic [CW-1:0]        wr_count_o
);
   localparam int unsigned LVL_W = (NLEVELS > 1) ? $clog2(NLEVELS) : 1;

   setup_form_e       form;
   logic [AW-1:0]     offset;
   logic [LVL_W-1:0]  level;

   assign form  = valid_i ? classify(instr_i) : FORM_NONE;
   assign level = LVL_W'(instr_i[7]);

   always_comb begin
      offset     = '0;
      wr_count_o = '0;
      unique case (form)
         FORM_REGCNT: begin
            offset     = AW'({instr_i[31:20], 1'b0});
            wr_count_o = rs1_i;
         end
         FORM_IMMCNT: begin
            offset     = AW'({instr_i[19:15], 1'b0});
            wr_count_o = CW'(instr_i[31:20]);
         end
         default: begin
            offset     = '0;
            wr_count_o = '0;
         end
      endcase
   end

   assign wr_start_o = pc_i + AW'(4);
   assign wr_end_o   = pc_i + offset;

   for (genvar g = 0; g < NLEVELS; g++) begin : g_wr
      assign wr_en_o[g] = (form != FORM_NONE) && (level == LVL_W'(g));
   end
endmodule

// File: rtl/hwloop_level.sv
module hwloop_level #(
   parameter int unsigned AW = 32,
   parameter int unsigned CW = 32
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          wr_en_i,
   input  logic [AW-1:0] wr_start_i,
   input  logic [AW-1:0] wr_end_i,
   input  logic [CW-1:0] wr_count_i,
   input  logic          fetch_valid_i,
   input  logic [AW-1:0] fetch_pc_i,
   input  logic          take_i,
   output logic          hit_o,
   output logic          more_o,
   output logic [AW-1:0] start_o,
   output logic [AW-1:0] end_o,
   output logic [CW-1:0] count_o
);
   logic [AW-1:0] start_q, end_q;
   logic [CW-1:0] count_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         start_q <= '0;
         end_q   <= '0;
         count_q <= '0;
      end else if (wr_en_i) begin
         start_q <= wr_start_i;
         end_q   <= wr_end_i;
         count_q <= wr_count_i;
      end else if (take_i) begin
         count_q <= count_q - CW'(1);
      end
   end

   assign hit_o   = fetch_valid_i && (fetch_pc_i == end_q) && (count_q != '0);
   assign more_o  = count_q > CW'(1);
   assign start_o = start_q;
   assign end_o   = end_q;
   assign count_o = count_q;

   // R11: without a write or a step the count is held
   p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_en_i && !take_i) |=> $stable(count_q));
   // R10: a setup write wins over a step in the same cycle
   p_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i |=> (count_q == $past(wr_count_i)) && (end_q == $past(wr_end_i)));
   // R7: a granted step lowers the count by exactly one
   p_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_i && !wr_en_i) |=> count_q == $past(count_q) - CW'(1));
   // R7: a spent level is never granted a step
   p_spent_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (count_q == '0) |-> !take_i);
endmodule

// File: rtl/hwloop_select.sv
module hwloop_select #(
   parameter int unsigned AW      = 32,
   parameter int unsigned NLEVELS = 2
) (
   input  logic [NLEVELS-1:0]    hit_i,
   input  logic [NLEVELS-1:0]    more_i,
   input  logic [NLEVELS*AW-1:0] start_i,
   output logic [NLEVELS-1:0]    take_o,
   output logic                  redirect_o,
   output logic [AW-1:0]         target_o
);
   logic [NLEVELS-1:0] want;
   logic [NLEVELS:0]   blocked;

   assign blocked[0] = 1'b0;
   for (genvar g = 0; g < NLEVELS; g++) begin : g_prio
      assign want[g]      = hit_i[g] && more_i[g];
      assign take_o[g]    = hit_i[g] && !blocked[g];
      assign blocked[g+1] = blocked[g] || want[g];
   end

   assign redirect_o = blocked[NLEVELS];

   always_comb begin
      target_o = '0;
      for (int i = NLEVELS - 1; i >= 0; i--) begin
         if (want[i]) target_o = start_i[i*AW +: AW];
      end
   end
endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl #(
   parameter int unsigned AW      = 32,
   parameter int unsigned CW      = 32,
   parameter int unsigned NLEVELS = 2
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 setup_valid_i,
   input  logic [31:0]          setup_instr_i,
   input  logic [AW-1:0]        setup_pc_i,
   input  logic [CW-1:0]        rs1_val_i,
   input  logic                 fetch_valid_i,
   input  logic [AW-1:0]        fetch_pc_i,
   output logic                 redirect_o,
   output logic [AW-1:0]        redirect_pc_o,
   output logic [NLEVELS*AW-1:0] loop_start_o,
   output logic [NLEVELS*AW-1:0] loop_end_o,
   output logic [NLEVELS*CW-1:0] loop_count_o
);
   if (NLEVELS != 2) begin : g_chk_levels
      $error("hwloop_ctrl: the level field is one bit, NLEVELS must be 2");
   end
   if (AW < 14) begin : g_chk_aw
      $error("hwloop_ctrl: AW must hold a 13-bit offset");
   end
   if (CW < 12) begin : g_chk_cw
      $error("hwloop_ctrl: CW must hold a 12-bit immediate count");
   end

   logic [NLEVELS-1:0] wr_en, hit, more, take;
   logic [AW-1:0]      wr_start, wr_end;
   logic [CW-1:0]      wr_count;

   hwloop_decode #(.AW(AW), .CW(CW), .NLEVELS(NLEVELS)) u_decode (
      .valid_i    (setup_valid_i),
      .instr_i    (setup_instr_i),
      .pc_i       (setup_pc_i),
      .rs1_i      (rs1_val_i),
      .wr_en_o    (wr_en),
      .wr_start_o (wr_start),
      .wr_end_o   (wr_end),
      .wr_count_o (wr_count)
   );

   for (genvar g = 0; g < NLEVELS; g++) begin : g_level
      hwloop_level #(.AW(AW), .CW(CW)) u_level (
         .clk_i         (clk_i),
         .rst_ni        (rst_ni),
         .wr_en_i       (wr_en[g]),
         .wr_start_i    (wr_start),
         .wr_end_i      (wr_end),
         .wr_count_i    (wr_count),
         .fetch_valid_i (fetch_valid_i),
         .fetch_pc_i    (fetch_pc_i),
         .take_i        (take[g]),
         .hit_o         (hit[g]),
         .more_o        (more[g]),
         .start_o       (loop_start_o[g*AW +: AW]),
         .end_o         (loop_end_o[g*AW +: AW]),
         .count_o       (loop_count_o[g*CW +: CW])
      );
   end

   hwloop_select #(.AW(AW), .NLEVELS(NLEVELS)) u_select (
      .hit_i      (hit),
      .more_i     (more),
      .start_i    (loop_start_o),
      .take_o     (take),
      .redirect_o (redirect_o),
      .target_o   (redirect_pc_o)
   );

   // R11: no fetch, no redirect
   p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !fetch_valid_i |-> !redirect_o);
   // R6: a redirect always lands on the start of a level whose end is fetched
   p_target_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      redirect_o |-> ((fetch_pc_i == loop_end_o[0 +: AW]) && (redirect_pc_o == loop_start_o[0 +: AW]))
                  || ((fetch_pc_i == loop_end_o[AW +: AW]) && (redirect_pc_o == loop_start_o[AW +: AW])));
   // R8: the inner level wins and the outer count is left alone
   p_inner_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fetch_valid_i && fetch_pc_i == loop_end_o[0 +: AW] && loop_count_o[0 +: CW] > CW'(1)
       && !setup_valid_i)
      |-> redirect_o && (redirect_pc_o == loop_start_o[0 +: AW]) ##1 $stable(loop_count_o[CW +: CW]));
endmodule

// File: tb/hwloop_ctrl_tb.sv
module hwloop_ctrl_tb;
   localparam int AW = 32;
   localparam int CW = 32;

   typedef struct packed {
      logic        is_setup;
      logic [31:0] instr;
      logic [31:0] pc;
      logic [31:0] rs1;
      logic        exp_red;
      logic [31:0] exp_tgt;
   } row_t;

   // outer: imm form, level 1, count 2, end offset 16 -> start 0x104 end 0x120
   localparam logic [31:0] OUTER = {12'd2, 5'd16, 3'b101, 4'd0, 1'b1, 7'b1111011};
   // inner: reg form, level 0, offset 8 -> start 0x10C end 0x118, count from rs1
   localparam logic [31:0] INNER = {12'd8, 5'd5, 3'b100, 4'd0, 1'b0, 7'b1111011};

   localparam int NROWS = 18;
   localparam row_t TABLE [NROWS] = '{
      '{1'b1, OUTER, 32'h100, 32'd0, 1'b0, 32'h0},
      '{1'b0, 32'h0, 32'h104, 32'd0, 1'b0, 32'h0},
      '{1'b1, INNER, 32'h108, 32'd3, 1'b0, 32'h0},
      '{1'b0, 32'h0, 32'h10C, 32'd0, 1'b0, 32'h0},
      '{1'b0, 32'h0, 32'h118, 32'd0, 1'b1, 32'h10C},
      '{1'b0, 32'h0, 32'h10C, 32'd0, 1'b0, 32'h0},
      '{1'b0, 32'h0, 32'h118, 32'd0, 1'b1, 32'h10C},
      '{1'b0, 32'h0, 32'h118, 32'd0, 1'b0, 32'h0},
      '{1'b0, 32'h0, 32'h11C, 32'd0, 1'b0, 32'h0},
      '{1'b0, 32'h0, 32'h120, 32'd0, 1'b1, 32'h104},
      '{1'b0, 32'h0, 32'h104, 32'd0, 1'b0, 32'h0},
      '{1'b1, INNER, 32'h108, 32'd3, 1'b0, 32'h0},
      '{1'b0, 32'h0, 32'h118, 32'd0, 1'b1, 32'h10C},
      '{1'b0, 32'h0, 32'h118, 32'd0, 1'b1, 32'h10C},
      '{1'b0, 32'h0, 32'h118, 32'd0, 1'b0, 32'h0},
      '{1'b0, 32'h0, 32'h120, 32'd0, 1'b0, 32'h0},
      '{1'b0, 32'h0, 32'h120, 32'd0, 1'b0, 32'h0},
      '{1'b0, 32'h0, 32'h118, 32'd0, 1'b0, 32'h0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          setup_valid = 1'b0;
   logic [31:0]   setup_instr = '0;
   logic [AW-1:0] setup_pc = '0;
   logic [CW-1:0] rs1_val = '0;
   logic          fetch_valid = 1'b0;
   logic [AW-1:0] fetch_pc = '0;
   logic          redirect;
   logic [AW-1:0] redirect_pc;
   logic [2*AW-1:0] lstart, lend;
   logic [2*CW-1:0] lcount;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   hwloop_ctrl #(.AW(AW), .CW(CW), .NLEVELS(2)) u_dut (
      .clk_i(clk), .rst_ni(rst_n),
      .setup_valid_i(setup_valid), .setup_instr_i(setup_instr),
      .setup_pc_i(setup_pc), .rs1_val_i(rs1_val),
      .fetch_valid_i(fetch_valid), .fetch_pc_i(fetch_pc),
      .redirect_o(redirect), .redirect_pc_o(redirect_pc),
      .loop_start_o(lstart), .loop_end_o(lend), .loop_count_o(lcount)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // drive one cycle at the falling edge, sample 1 ns later, before the rising edge
   task automatic cycle(input logic sv, input logic [31:0] ins, input logic [31:0] spc,
                        input logic [31:0] r1, input logic fv, input logic [31:0] fpc);
      @(negedge clk);
      setup_valid = sv; setup_instr = ins; setup_pc = spc; rs1_val = r1;
      fetch_valid = fv; fetch_pc = fpc;
      #1;
   endtask

   task automatic idle();
      @(negedge clk);
      setup_valid = 1'b0; fetch_valid = 1'b0;
      #1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; setup_valid = 1'b0; fetch_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int inner_red;
      int outer_red;
      inner_red = 0;
      outer_red = 0;
      do_reset();
      #1;
      // R1 reset state
      check("R1 start", {lstart}, 64'h0);
      check("R1 end",   {lend},   64'h0);
      check("R1 count", {lcount}, 64'h0);
      check("R1 redirect", {63'd0, redirect}, 64'h0);

      // R4 ignored setups
      cycle(1'b1, {12'd2, 5'd16, 3'b110, 4'd0, 1'b1, 7'b1111011}, 32'h40, 32'd9, 1'b0, 32'h0);
      cycle(1'b1, {12'd2, 5'd16, 3'b101, 4'd1, 1'b0, 7'b1111011}, 32'h40, 32'd9, 1'b0, 32'h0);
      cycle(1'b1, {12'd2, 5'd16, 3'b100, 4'd0, 1'b0, 7'b0101011}, 32'h40, 32'd9, 1'b0, 32'h0);
      cycle(1'b0, OUTER, 32'h40, 32'd9, 1'b0, 32'h0);
      idle();
      check("R4 count untouched", {lcount}, 64'h0);
      check("R4 end untouched",   {lend},   64'h0);

      // nested loop walk from the table
      for (int i = 0; i < NROWS; i++) begin
         if (TABLE[i].is_setup)
            cycle(1'b1, TABLE[i].instr, TABLE[i].pc, TABLE[i].rs1, 1'b0, 32'h0);
         else
            cycle(1'b0, 32'h0, 32'h0, 32'h0, 1'b1, TABLE[i].pc);
         check($sformatf("R6 R7 row %0d redirect", i), {63'd0, redirect}, {63'd0, TABLE[i].exp_red});
         if (TABLE[i].exp_red)
            check($sformatf("R6 row %0d target", i), {32'd0, redirect_pc}, {32'd0, TABLE[i].exp_tgt});
         if (redirect && redirect_pc == 32'h10C) inner_red++;
         if (redirect && redirect_pc == 32'h104) outer_red++;
         if (i == 0) begin
            idle();
            // R3 R5 immediate form into level 1 only
            check("R3 start1", {32'd0, lstart[63:32]}, 64'h104);
            check("R3 end1",   {32'd0, lend[63:32]},   64'h120);
            check("R3 count1", {32'd0, lcount[63:32]}, 64'd2);
            check("R5 level0 untouched", {32'd0, lcount[31:0]}, 64'd0);
         end
         if (i == 2) begin
            idle();
            // R2 register form into level 0
            check("R2 start0", {32'd0, lstart[31:0]}, 64'h10C);
            check("R2 end0",   {32'd0, lend[31:0]},   64'h118);
            check("R2 count0", {32'd0, lcount[31:0]}, 64'd3);
         end
      end
      idle();
      check("R6 inner iterations", 64'(inner_red), 64'd4);
      check("R6 outer iterations", 64'(outer_red), 64'd1);
      check("R7 both spent", {lcount}, 64'h0);

      // R11 fetch strobe low at an armed end
      do_reset();
      cycle(1'b1, INNER, 32'h108, 32'd4, 1'b0, 32'h0);
      cycle(1'b0, 32'h0, 32'h0, 32'h0, 1'b0, 32'h118);
      check("R11 no redirect", {63'd0, redirect}, 64'h0);
      idle();
      check("R11 count kept", {32'd0, lcount[31:0]}, 64'd4);

      // R8 R9 shared end 0x220
      do_reset();
      cycle(1'b1, {12'h010, 5'd1, 3'b100, 4'd0, 1'b0, 7'b1111011}, 32'h200, 32'd3, 1'b0, 32'h0);
      cycle(1'b1, {12'd3, 5'd24, 3'b101, 4'd0, 1'b1, 7'b1111011}, 32'h1F0, 32'd0, 1'b0, 32'h0);
      cycle(1'b0, 32'h0, 32'h0, 32'h0, 1'b1, 32'h220);
      check("R8 redirect", {63'd0, redirect}, 64'h1);
      check("R8 inner target", {32'd0, redirect_pc}, 64'h204);
      idle();
      check("R8 outer count kept", {32'd0, lcount[63:32]}, 64'd3);
      check("R8 inner count", {32'd0, lcount[31:0]}, 64'd2);
      cycle(1'b0, 32'h0, 32'h0, 32'h0, 1'b1, 32'h220);
      check("R8 second inner target", {32'd0, redirect_pc}, 64'h204);
      cycle(1'b0, 32'h0, 32'h0, 32'h0, 1'b1, 32'h220);
      check("R9 redirect", {63'd0, redirect}, 64'h1);
      check("R9 outer target", {32'd0, redirect_pc}, 64'h1F4);
      idle();
      check("R9 counts", {lcount}, {32'd2, 32'd0});

      // R10 setup and matching fetch in one cycle
      cycle(1'b1, {12'd5, 5'd4, 3'b101, 4'd0, 1'b1, 7'b1111011}, 32'h300, 32'd0, 1'b1, 32'h220);
      check("R10 old values used", {32'd0, redirect_pc}, 64'h1F4);
      check("R10 old redirect", {63'd0, redirect}, 64'h1);
      idle();
      check("R10 new count", {32'd0, lcount[63:32]}, 64'd5);
      check("R10 new end", {32'd0, lend[63:32]}, 64'h308);
      cycle(1'b0, 32'h0, 32'h0, 32'h0, 1'b1, 32'h220);
      check("R10 old end dead", {63'd0, redirect}, 64'h0);
      cycle(1'b0, 32'h0, 32'h0, 32'h0, 1'b1, 32'h308);
      check("R10 new loop target", {32'd0, redirect_pc}, 64'h304);
      idle();

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule